// File: doc/BRIEF.md
# Bus Ready Signal Combiner

This block forms the single internal ready indication that ends a bus cycle or stretches it with wait states. Two ready sources feed it. The synchronous ready input is taken to be aligned to the bus clock already, so it reaches the combined ready with no register in the path. The asynchronous ready input has no timing relation to the clock. It first passes through a half-period synchronizer: one flop captures it on the falling clock edge and a second flop passes it on at the next rising edge.

The combined ready is the OR of the synchronous path and the synchronized asynchronous path. The synchronous pin can be given over to general-purpose I/O through a mode input. In that mode the internal synchronous ready is held low, so only the asynchronous path decides readiness. The bus sequencer marks its wait-state decision slot with a strobe. In that slot the block raises a wait-state request whenever the combined ready is low.

Top module: `bus_rdy_merge`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, both synchronizer flops are clear, so the asynchronous path contributes a low ready whatever the asynchronous input did during reset.
- R2: When the synchronous ready input is high and the pin-mode input is low, the combined ready is high in the same cycle, whatever the asynchronous input is.
- R3: A level on the asynchronous ready input that is stable across a falling clock edge reaches the combined ready at the next rising edge. A value presented just after a rising edge is therefore visible one clock later.
- R4: When the synchronous ready input is low, the combined ready equals the synchronized asynchronous ready.
- R5: When the pin-mode input is high (general-purpose I/O), the synchronous ready input has no effect: the combined ready equals the synchronized asynchronous ready.
- R6: The combined ready is the logical OR of the effective synchronous ready and the synchronized asynchronous ready.
- R7: In a cycle where the wait-slot strobe is high, the wait-state request is high exactly when the combined ready is low.
- R8: In a cycle where the wait-slot strobe is low, the wait-state request is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_rdy_i | input | 1 | Synchronous ready, active high, already aligned to clk |
| async_rdy_i | input | 1 | Asynchronous ready, active high |
| srdy_gpio_i | input | 1 | High selects general-purpose I/O use of the synchronous ready pin |
| wait_slot_i | input | 1 | High during the wait-state decision slot of a bus cycle |
| rdy_o | output | 1 | Combined ready |
| wait_req_o | output | 1 | Wait-state request |

## Verification
The synchronous path and the wait-state request are combinational. They are due in the same cycle as their inputs. The asynchronous path is due one clock after a value presented just after a rising edge, because the falling-edge flop takes it mid-cycle and the rising-edge flop releases it at the next edge. The bench drives every input 1 ns after a rising edge, so the asynchronous level is stable across the falling edge. It samples outputs 4 ns after the rising edge, after the falling edge but before the next rising edge. It compares them against a model that keeps a per-cycle queue of asynchronous values and reads the previous entry. During reset that queue receives zeros.

// File: rtl/bus_rdy_merge.sv
module bus_rdy_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_rdy_i,
  input  logic async_rdy_i,
  input  logic srdy_gpio_i,
  input  logic wait_slot_i,
  output logic rdy_o,
  output logic wait_req_o
);

  logic ardy_half;
  logic ardy_sync;
  logic srdy_eff;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ardy_half <= 1'b0;
    else        ardy_half <= async_rdy_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ardy_sync <= 1'b0;
    else        ardy_sync <= ardy_half;
  end

  assign srdy_eff   = sync_rdy_i & ~srdy_gpio_i;
  assign rdy_o      = srdy_eff | ardy_sync;
  assign wait_req_o = wait_slot_i & ~rdy_o;

endmodule

// File: rtl/bus_rdy_merge_chk.sv
module bus_rdy_merge_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_rdy_i,
  input logic srdy_gpio_i,
  input logic wait_slot_i,
  input logic rdy_o,
  input logic wait_req_o
);

  // R2
  sync_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rdy_i && !srdy_gpio_i) |-> rdy_o);

  // R7
  wait_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_slot_i && !rdy_o) |-> wait_req_o);

  // R7
  no_wait_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_o |-> !wait_req_o);

  // R8
  no_wait_outside_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_slot_i |-> !wait_req_o);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n) && (srdy_gpio_i || !sync_rdy_i)) |-> !rdy_o);

endmodule

bind bus_rdy_merge bus_rdy_merge_chk chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .sync_rdy_i(sync_rdy_i),
  .srdy_gpio_i(srdy_gpio_i),
  .wait_slot_i(wait_slot_i),
  .rdy_o(rdy_o),
  .wait_req_o(wait_req_o)
);

// File: tb/bus_rdy_merge_tb.sv
`timescale 1ns/1ps
module bus_rdy_merge_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_rdy_i = 1'b0;
  logic async_rdy_i = 1'b0;
  logic srdy_gpio_i = 1'b0;
  logic wait_slot_i = 1'b0;
  logic rdy_o;
  logic wait_req_o;

  int checks = 0;
  int errors = 0;
  int cyc_since_rst = 0;
  bit ahist[$];

  always #2.5 clk = ~clk;

  bus_rdy_merge dut_i (
    .clk(clk), .rst_n(rst_n), .sync_rdy_i(sync_rdy_i), .async_rdy_i(async_rdy_i),
    .srdy_gpio_i(srdy_gpio_i), .wait_slot_i(wait_slot_i),
    .rdy_o(rdy_o), .wait_req_o(wait_req_o)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  // One clock: drive 1 ns after the rising edge, sample 4 ns after it.
  task automatic step(bit rst, bit s, bit a, bit g, bit w);
    bit a_prev;
    bit s_eff;
    bit exp_rdy;
    string tag;
    @(posedge clk);
    #1;
    rst_n = rst; sync_rdy_i = s; async_rdy_i = a; srdy_gpio_i = g; wait_slot_i = w;
    ahist.push_back(rst ? a : 1'b0);
    if (ahist.size() > 4) void'(ahist.pop_front());
    #3;
    if (!rst) begin
      cyc_since_rst = 0;
      return;
    end
    cyc_since_rst++;
    a_prev = (ahist.size() >= 2) ? ahist[ahist.size()-2] : 1'b0;
    s_eff = s && !g;
    exp_rdy = s_eff || a_prev;
    if (cyc_since_rst == 1)      tag = "R1";
    else if (g)                  tag = "R5";
    else if (s)                  tag = "R2";
    else if (a_prev != a)        tag = "R3";
    else                         tag = "R4";
    check(tag, rdy_o, exp_rdy);
    check("R6", rdy_o, s_eff | a_prev);
    check(w ? "R7" : "R8", wait_req_o, w && !exp_rdy);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: async high throughout reset must not leak into the first cycle
    step(0, 0, 1, 0, 1);
    step(0, 0, 1, 0, 1);
    step(1, 0, 1, 0, 1);
    step(1, 0, 1, 0, 1);
    // R3 / R4: async edges seen one clock later
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 1);
    step(1, 0, 1, 0, 0);
    step(1, 0, 0, 0, 1);
    step(1, 0, 1, 0, 1);
    step(1, 0, 0, 0, 0);
    // R2: sync high dominates
    step(1, 1, 0, 0, 1);
    step(1, 1, 0, 0, 1);
    step(1, 1, 1, 0, 1);
    step(1, 0, 0, 0, 1);
    step(1, 0, 0, 0, 1);
    // R5: gpio mode masks sync
    step(1, 1, 0, 1, 1);
    step(1, 1, 0, 1, 1);
    step(1, 1, 1, 1, 1);
    step(1, 1, 1, 1, 1);
    step(1, 1, 0, 1, 0);
    step(1, 1, 0, 1, 1);
    step(1, 1, 0, 0, 1);
    // R1 again: mid-run reset with async high
    step(0, 0, 1, 0, 1);
    step(1, 0, 1, 0, 1);
    step(1, 0, 1, 0, 1);
    // mixed pattern
    for (int i = 0; i < 64; i++)
      step(1, (i % 5) == 0, (i % 3) != 1, (i % 7) < 2, (i % 2) == 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule